// File: doc/BRIEF.md
# OTP Memory Byte Programming Sequencer

This block programs an external byte-wide one-time-programmable memory. Software or a host sequencer gives a first and a last address and pulses start. For each address the controller drives the byte taken from a data source port. It fires fixed-length active-low program pulses on the memory's chip-enable line while it requests the high programming voltage. After every pulse it reads the byte back. It moves to the next address on the first good read-back. If a byte still reads wrong after the retry cap, it stops with a failure.

Once the last address is programmed, the block reads the whole range back twice and compares every byte with the source. The first pass requests the nominal supply. The second pass requests the low supply. Supply switching is external: the block only drives select outputs. Several memories can share every line except chip-enable, because a device whose chip-enable stays high is never programmed.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, and in idle, the outputs are quiet: chip-enable and output-enable are high, the data driver is off, `vpp_hi_o` is 0, `vcc_sel_o` is 00, and done and fail are 0.
- R2: Each program pulse holds `mem_ce_n_o` low for exactly PULSE_US*CYC_PER_US cycles. The address stays unchanged while chip-enable is low. The source byte for that address is on `mem_dq_o` for the whole pulse.
- R3: The pulse count for a byte never exceeds MAX_PULSES (25). A byte that needs exactly 25 pulses succeeds. A byte that still fails after 25 pulses ends the run with fail set, `fail_addr_o` equal to that address, and no later address touched.
- R4: Exactly one verify read follows every pulse. The first matching verify moves on to the next address with no further pulse.
- R5: During program and verify, `vpp_hi_o` is 1 and `vcc_sel_o` is 01 (raised supply). A verify read holds output-enable low with chip-enable high.
- R6: After the last address, two check passes read every address in the range with chip-enable and output-enable low and `vpp_hi_o` 0. The first pass uses `vcc_sel_o` = 00 (nominal) and the second uses 10 (low). A mismatch ends the run with fail and the failing address.
- R7: The data driver (`mem_dq_oe_o`) is never on while output-enable is low.
- R8: `done_o` is high for exactly one cycle per run. `fail_o` and `fail_addr_o` hold their values until the next accepted start.
- R9: Start and the two addresses are sampled only in idle. A start while busy, or address changes while busy, have no effect. While `abort_i` is high, a start in idle is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a run (sampled in idle) |
| abort_i | input | 1 | Refuses a start while high in idle |
| first_addr_i | input | ADDR_W | First address of the range |
| last_addr_i | input | ADDR_W | Last address of the range (>= first) |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Run ended in failure (held) |
| fail_addr_o | output | ADDR_W | Address that failed (held) |
| src_addr_o | output | ADDR_W | Address whose byte the source must present |
| src_data_i | input | DATA_W | Byte to program at `src_addr_o` |
| mem_addr_o | output | ADDR_W | Memory address lines |
| mem_dq_o | output | DATA_W | Memory data out |
| mem_dq_oe_o | output | 1 | Data driver enable |
| mem_dq_i | input | DATA_W | Memory data in |
| mem_ce_n_o | output | 1 | Chip-enable, active low (program pulse) |
| mem_oe_n_o | output | 1 | Output-enable, active low |
| vpp_hi_o | output | 1 | Request programming voltage |
| vcc_sel_o | output | 2 | Supply select: 00 nominal, 01 raised, 10 low |

## Verification
The hardest state to reach is a failure in the second check pass only. By then every byte has programmed and verified, and it has also passed the nominal-supply pass. The bench memory model therefore makes its read value depend on the supply select. One address returns a corrupted byte only while the low supply is selected. This drives the run through a clean first pass into a late failure at a known address. The retry cap is reached by giving one address a required pulse count of exactly 25, and then 26.

// File: rtl/otp_prog_pkg.sv
// Shared types for the OTP programming sequencer.
// Assumes nothing beyond SystemVerilog-2017 enums.
package otp_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PSET,
        ST_PULSE,
        ST_PHOLD,
        ST_VSET,
        ST_VREAD,
        ST_VHOLD,
        ST_CSET,
        ST_CREAD,
        ST_CHOLD,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        SUP_NOM  = 2'b00,
        SUP_PROG = 2'b01,
        SUP_LOW  = 2'b10
    } supply_sel_e;

endpackage

// File: rtl/otp_prog_timer.sv
// Phase timer: on load it starts a phase that lasts len_i cycles, and it
// flags the last cycle of that phase.
// Assumes len_i >= 1.
module otp_prog_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load the phase length, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= len_i - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/otp_prog_addr.sv
// Address walker: latches a range, steps through it, can rewind to the
// first address, and reports when it sits on the last one.
// Assumes last >= first.
module otp_prog_addr #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] first_i,
    input  logic [ADDR_W-1:0] last_i,
    input  logic              step_i,
    input  logic              rewind_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              at_end_o
);
    logic [ADDR_W-1:0] first_q, last_q, addr_q;

    // Hold the range bounds captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
        end else if (load_i) begin
            first_q <= first_i;
            last_q  <= last_i;
        end
    end

    // Move the current address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load_i)
            addr_q <= first_i;
        else if (rewind_i)
            addr_q <= first_q;
        else if (step_i)
            addr_q <= addr_q + ADDR_W'(1);
    end

    assign addr_o   = addr_q;
    assign at_end_o = (addr_q == last_q);
endmodule

// File: rtl/otp_prog_seq.sv
// OTP byte programming sequencer (top).
// Walks an address range. Per byte it applies pulse / verify rounds up to
// MAX_PULSES, then runs two whole-range check passes at nominal and low
// supply. Assumes src_data_i follows src_addr_o combinationally and is
// stable while the address is held.
module otp_prog_seq
    import otp_prog_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int CYC_PER_US = 50,
    parameter int PULSE_US   = 100,
    parameter int SETUP_CYC  = 4,
    parameter int READ_CYC   = 4,
    parameter int HOLD_CYC   = 4,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [ADDR_W-1:0] first_addr_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [ADDR_W-1:0] src_addr_o,
    input  logic [DATA_W-1:0] src_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    output logic              vpp_hi_o,
    output logic [1:0]        vcc_sel_o
);
    localparam int PULSE_CYC = PULSE_US * CYC_PER_US;
    localparam int LEN_AB    = (SETUP_CYC > READ_CYC) ? SETUP_CYC : READ_CYC;
    localparam int LEN_ABC   = (LEN_AB > HOLD_CYC) ? LEN_AB : HOLD_CYC;
    localparam int MAX_LEN   = (LEN_ABC > PULSE_CYC) ? LEN_ABC : PULSE_CYC;
    localparam int CNT_W     = $clog2(MAX_LEN + 1);
    localparam int PCNT_W    = $clog2(MAX_PULSES + 1);

    seq_state_e        state_q, state_d;
    logic              tmr_exp;
    logic              accept, do_step, do_rewind, set_fail, pass_adv;
    logic              at_end, match_q, pass_q, fail_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic [ADDR_W-1:0] addr, fail_addr_q;

    // Length in cycles of the phase a state represents.
    function automatic logic [CNT_W-1:0] phase_len(seq_state_e s);
        case (s)
            ST_PSET, ST_VSET, ST_CSET:    return CNT_W'(SETUP_CYC);
            ST_PULSE:                     return CNT_W'(PULSE_CYC);
            ST_VREAD, ST_CREAD:           return CNT_W'(READ_CYC);
            ST_PHOLD, ST_VHOLD, ST_CHOLD: return CNT_W'(HOLD_CYC);
            default:                      return CNT_W'(1);
        endcase
    endfunction

    otp_prog_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (state_d != state_q),
        .len_i     (phase_len(state_d)),
        .expired_o (tmr_exp)
    );

    otp_prog_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .first_i  (first_addr_i),
        .last_i   (last_addr_i),
        .step_i   (do_step),
        .rewind_i (do_rewind),
        .addr_o   (addr),
        .at_end_o (at_end)
    );

    // Next-state and sequencing decisions.
    always_comb begin
        state_d   = state_q;
        accept    = 1'b0;
        do_step   = 1'b0;
        do_rewind = 1'b0;
        set_fail  = 1'b0;
        pass_adv  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i && !abort_i) begin
                accept  = 1'b1;
                state_d = ST_PSET;
            end
            ST_PSET:  if (tmr_exp) state_d = ST_PULSE;
            ST_PULSE: if (tmr_exp) state_d = ST_PHOLD;
            ST_PHOLD: if (tmr_exp) state_d = ST_VSET;
            ST_VSET:  if (tmr_exp) state_d = ST_VREAD;
            ST_VREAD: if (tmr_exp) state_d = ST_VHOLD;
            ST_VHOLD: if (tmr_exp) begin
                if (match_q) begin
                    if (at_end) begin
                        do_rewind = 1'b1;
                        state_d   = ST_CSET;
                    end else begin
                        do_step = 1'b1;
                        state_d = ST_PSET;
                    end
                end else if (pcnt_q == PCNT_W'(MAX_PULSES)) begin
                    set_fail = 1'b1;
                    state_d  = ST_DONE;
                end else begin
                    state_d = ST_PSET;
                end
            end
            ST_CSET:  if (tmr_exp) state_d = ST_CREAD;
            ST_CREAD: if (tmr_exp) state_d = ST_CHOLD;
            ST_CHOLD: if (tmr_exp) begin
                if (!match_q) begin
                    set_fail = 1'b1;
                    state_d  = ST_DONE;
                end else if (!at_end) begin
                    do_step = 1'b1;
                    state_d = ST_CSET;
                end else if (!pass_q) begin
                    do_rewind = 1'b1;
                    pass_adv  = 1'b1;
                    state_d   = ST_CSET;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Per-byte pulse counter, incremented as each pulse begins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (accept || do_step || do_rewind)
            pcnt_q <= '0;
        else if (state_q == ST_PSET && state_d == ST_PULSE)
            pcnt_q <= pcnt_q + PCNT_W'(1);
    end

    // Capture the read-back comparison on the last read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_q <= 1'b0;
        else if ((state_q == ST_VREAD || state_q == ST_CREAD) && tmr_exp)
            match_q <= (mem_dq_i == src_data_i);
    end

    // Check-pass selector: 0 nominal supply, 1 low supply.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) pass_q <= 1'b0;
        else if (pass_adv)    pass_q <= 1'b1;
    end

    // Failure flag and address, held until the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else if (set_fail) begin
            fail_q      <= 1'b1;
            fail_addr_q <= addr;
        end
    end

    // Memory-side and supply outputs decoded from the state.
    always_comb begin
        mem_ce_n_o  = 1'b1;
        mem_oe_n_o  = 1'b1;
        mem_dq_oe_o = 1'b0;
        vpp_hi_o    = 1'b0;
        vcc_sel_o   = SUP_NOM;
        unique case (state_q)
            ST_PSET, ST_PHOLD: begin
                mem_dq_oe_o = 1'b1; vpp_hi_o = 1'b1; vcc_sel_o = SUP_PROG;
            end
            ST_PULSE: begin
                mem_dq_oe_o = 1'b1; vpp_hi_o = 1'b1; vcc_sel_o = SUP_PROG;
                mem_ce_n_o  = 1'b0;
            end
            ST_VSET, ST_VHOLD: begin
                vpp_hi_o = 1'b1; vcc_sel_o = SUP_PROG;
            end
            ST_VREAD: begin
                vpp_hi_o = 1'b1; vcc_sel_o = SUP_PROG; mem_oe_n_o = 1'b0;
            end
            ST_CSET, ST_CHOLD: vcc_sel_o = pass_q ? SUP_LOW : SUP_NOM;
            ST_CREAD: begin
                vcc_sel_o  = pass_q ? SUP_LOW : SUP_NOM;
                mem_ce_n_o = 1'b0;
                mem_oe_n_o = 1'b0;
            end
            default: ;
        endcase
    end

    assign done_o      = (state_q == ST_DONE);
    assign fail_o      = fail_q;
    assign fail_addr_o = fail_addr_q;
    assign src_addr_o  = addr;
    assign mem_addr_o  = addr;
    assign mem_dq_o    = src_data_i;
endmodule

// File: rtl/otp_prog_seq_chk.sv
// Property checker for otp_prog_seq, attached by bind. It observes ports
// only and keeps its own counters for pulse width and pulses per address.
module otp_prog_seq_chk #(
    parameter int ADDR_W     = 15,
    parameter int PULSE_CYC  = 5000,
    parameter int MAX_PULSES = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              done_o,
    input logic              fail_o,
    input logic [ADDR_W-1:0] fail_addr_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_dq_oe_o,
    input logic              mem_ce_n_o,
    input logic              mem_oe_n_o,
    input logic              vpp_hi_o,
    input logic [1:0]        vcc_sel_o
);
    logic [31:0]       low_run;
    logic [7:0]        pulses_here;
    logic [ADDR_W-1:0] addr_q;
    logic              ce_q;

    // Length of the current program-voltage chip-enable low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)                      low_run <= '0;
        else if (!mem_ce_n_o && vpp_hi_o) low_run <= low_run + 32'd1;
        else                             low_run <= '0;
    end

    // Pulses applied at the current address within one run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses_here <= '0;
            addr_q      <= '0;
            ce_q        <= 1'b1;
        end else begin
            addr_q <= mem_addr_o;
            ce_q   <= mem_ce_n_o;
            if (mem_addr_o != addr_q || done_o)
                pulses_here <= '0;
            else if (mem_ce_n_o && !ce_q && vpp_hi_o)
                pulses_here <= pulses_here + 8'd1;
        end
    end

    a_r7_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> !mem_dq_oe_o);

    a_r5_prog_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && vpp_hi_o) |-> (vcc_sel_o == 2'b01));

    a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && !$past(mem_ce_n_o)) |-> $stable(mem_addr_o));

    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ce_n_o) && $past(vpp_hi_o)) |-> (low_run == 32'(PULSE_CYC)));

    a_r3_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pulses_here) <= 32'(MAX_PULSES));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_fail_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> (fail_o && $stable(fail_addr_o)));
endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .ADDR_W     (ADDR_W),
    .PULSE_CYC  (PULSE_CYC),
    .MAX_PULSES (MAX_PULSES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_oe_o (mem_dq_oe_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .vpp_hi_o    (vpp_hi_o),
    .vcc_sel_o   (vcc_sel_o)
);

// File: tb/tb_otp_prog_seq.sv
// Bench: behavioural memory model with per-address pulse needs and a
// supply-dependent fault, range sweeps, retry cap edge, and idle sampling.
module tb_otp_prog_seq;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int CPU = 2;
    localparam int PUS = 3;
    localparam int PW = CPU * PUS;
    localparam int NA = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, abort = 1'b0;
    logic [AW-1:0] first_a = '0, last_a = '0;
    logic done, fail, dq_oe, ce_n, oe_n, vpp;
    logic [AW-1:0] fail_addr, src_addr, mem_addr;
    logic [DW-1:0] src_data, dq_o, dq_i;
    logic [1:0] vcc;

    int need[NA];
    int pulses[NA];
    int vreads[NA];
    int corrupt_low = -1;
    int cnom, clow, act, done_cnt, pw_err, sel_err, bus_err, data_err, lowlen;
    logic prev_ce, prev_oe;
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    otp_prog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .CYC_PER_US(CPU), .PULSE_US(PUS),
        .SETUP_CYC(2), .READ_CYC(2), .HOLD_CYC(1), .MAX_PULSES(25)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .first_addr_i(first_a), .last_addr_i(last_a),
        .done_o(done), .fail_o(fail), .fail_addr_o(fail_addr),
        .src_addr_o(src_addr), .src_data_i(src_data),
        .mem_addr_o(mem_addr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe),
        .mem_dq_i(dq_i), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n),
        .vpp_hi_o(vpp), .vcc_sel_o(vcc)
    );

    function automatic logic [DW-1:0] tgt(input logic [AW-1:0] a);
        return {a, 4'h5};
    endfunction

    assign src_data = tgt(src_addr);

    // Memory model read path.
    always_comb begin
        if (!oe_n) begin
            if (corrupt_low == int'(mem_addr) && vcc == 2'b10)
                dq_i = ~tgt(mem_addr);
            else if (pulses[mem_addr] >= need[mem_addr])
                dq_i = tgt(mem_addr);
            else
                dq_i = 8'hFF;
        end else begin
            dq_i = 8'h5A;
        end
    end

    // Port monitor and memory model update.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ce_n || !oe_n) act++;
            if (done) done_cnt++;
            if (dq_oe && !oe_n) bus_err++;
            if (!ce_n && vpp) begin
                lowlen++;
                if (dq_o != tgt(mem_addr)) data_err++;
                if (vcc != 2'b01) sel_err++;
            end
            if (ce_n && !prev_ce && vpp) begin
                if (lowlen != PW) pw_err++;
                pulses[mem_addr]++;
            end
            if (ce_n) lowlen = 0;
            if (!oe_n && prev_oe) begin
                if (ce_n) begin
                    vreads[mem_addr]++;
                    if (!(vpp && vcc == 2'b01)) sel_err++;
                end else begin
                    if (vpp) sel_err++;
                    if (vcc == 2'b00) cnom++;
                    else if (vcc == 2'b10) clow++;
                    else sel_err++;
                end
            end
        end
        prev_ce = ce_n;
        prev_oe = oe_n;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act_v, input int exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    task automatic clear_model();
        @(posedge clk);
        for (int i = 0; i < NA; i++) begin
            pulses[i] = 0;
            vreads[i] = 0;
        end
        cnom = 0; clow = 0; act = 0; done_cnt = 0;
        pw_err = 0; sel_err = 0; bus_err = 0; data_err = 0;
    endtask

    task automatic pulse_start(input int s, input int e);
        @(negedge clk);
        first_a = AW'(s);
        last_a  = AW'(e);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 40000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, req, "run completes", n, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic common_checks(input string tag);
        check(pw_err == 0, "R2", {tag, " pulse width"}, pw_err, 0);
        check(data_err == 0, "R2", {tag, " data during pulse"}, data_err, 0);
        check(sel_err == 0, "R5", {tag, " select levels"}, sel_err, 0);
        check(bus_err == 0, "R7", {tag, " driver vs output-enable"}, bus_err, 0);
        check(done_cnt == 1, "R8", {tag, " single done"}, done_cnt, 1);
    endtask

    // Global watchdog.
    initial begin
        #(5.0 * 190000);
        fails++;
        tests++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NA; i++) begin
            need[i] = 1;
            pulses[i] = 0;
            vreads[i] = 0;
        end
        lowlen = 0;
        prev_ce = 1'b1;
        prev_oe = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ce_n && oe_n && !dq_oe, "R1", "memory lines idle", {ce_n, oe_n, dq_oe}, 3'b110);
        check(!vpp && vcc == 2'b00, "R1", "supply selects idle", {vpp, vcc}, 0);
        check(!done && !fail, "R1", "done/fail low", {done, fail}, 0);

        // Sweep top half of the range with varied pulse needs (R3, R4, R6)
        for (int i = 0; i < NA; i++) need[i] = (i % 4) + 1;
        clear_model();
        pulse_start(8, 15);
        wait_done("R4");
        common_checks("sweep");
        check(!fail, "R6", "sweep passes", fail, 0);
        for (int a = 8; a < 16; a++) begin
            check(pulses[a] == need[a], "R4", $sformatf("pulses at %0d", a), pulses[a], need[a]);
            check(vreads[a] == pulses[a], "R4", $sformatf("verifies at %0d", a), vreads[a], pulses[a]);
        end
        check(cnom == 8 && clow == 8, "R6", "check reads nom/low", cnom * 100 + clow, 808);
        check(ce_n && oe_n && !vpp && vcc == 2'b00, "R1", "idle after run", vcc, 0);

        // Exactly 25 pulses succeeds (R3)
        for (int i = 0; i < NA; i++) need[i] = 1;
        need[3] = 25;
        clear_model();
        pulse_start(2, 4);
        wait_done("R3");
        common_checks("cap25");
        check(!fail && pulses[3] == 25, "R3", "25 pulses accepted", pulses[3], 25);

        // 26 needed: fails at the cap (R3)
        need[3] = 26;
        clear_model();
        pulse_start(2, 5);
        wait_done("R3");
        common_checks("cap26");
        check(fail && fail_addr == 3, "R3", "fail address", int'(fail_addr), 3);
        check(pulses[3] == 25, "R3", "stopped at cap", pulses[3], 25);
        check(pulses[4] == 0 && cnom == 0, "R3", "no later address", pulses[4] + cnom, 0);
        repeat (30) @(negedge clk);
        check(fail && fail_addr == 3, "R8", "fail held in idle", int'(fail_addr), 3);

        // Low-supply-only fault in second pass (R6)
        need[3] = 1;
        corrupt_low = 5;
        clear_model();
        pulse_start(0, 7);
        wait_done("R6");
        common_checks("lowfault");
        check(fail && fail_addr == 5, "R6", "second pass fail address", int'(fail_addr), 5);
        check(cnom == 8 && clow == 6, "R6", "reads before fail", cnom * 100 + clow, 806);
        corrupt_low = -1;

        // Abort refuses start (R9), fail stays held (R8)
        clear_model();
        abort = 1'b1;
        pulse_start(0, 3);
        repeat (40) @(negedge clk);
        abort = 1'b0;
        check(act == 0 && done_cnt == 0, "R9", "abort refuses start", act + done_cnt, 0);
        check(fail && fail_addr == 5, "R8", "fail kept after refused start", int'(fail_addr), 5);

        // Start/address changes while busy are ignored (R9)
        clear_model();
        pulse_start(0, 3);
        check(!fail, "R8", "fail cleared by start", fail, 0);
        repeat (30) @(negedge clk);
        first_a = AW'(9);
        last_a  = AW'(12);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R9");
        common_checks("busy");
        check(pulses[9] + pulses[12] == 0 && cnom == 4 && clow == 4, "R9",
              "busy inputs ignored", cnom * 100 + clow, 404);

        // Single-address range (R6 boundary)
        clear_model();
        pulse_start(6, 6);
        wait_done("R6");
        common_checks("single");
        check(!fail && pulses[6] == 1 && cnom == 1 && clow == 1, "R6",
              "single address", cnom * 100 + clow, 101);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule